// File: doc/BRIEF.md
# Write-Through Snooping Data Cache Controller

This block is a small direct-mapped data cache for one processor that shares a bus and main memory with other caches. Processor reads that hit are answered in the request cycle without touching the bus. Reads that miss fetch the whole line from memory, one word per bus beat, and install it. Every processor write goes straight through to memory as one bus write. A write that hits also updates the cached word. A write that misses leaves the cache alone, unless the write-allocate parameter is set; in that case the line is fetched after the write.

The controller also watches writes on the shared bus that carry another cache's originator ID. When such a write lands on a resident line, the local copy is invalidated by default. With the update parameter set, the observed data replaces the resident word and the line stays valid. Snooped reads, snooped writes to non-resident lines and the cache's own transactions have no effect. The processor handshake is a level request held until a one-cycle ready. Arbitration is reduced to a grant input. A bus beat completes in a cycle where both grant and memory acknowledge are high.

Top module: `wt_snoop_cache`

## Requirements
- R1: A read miss raises `bus_req` with `bus_we` low and fetches the line as WORDS beats at word addresses base+0, base+1, ... in rising order, where base is the request address with its low log2(WORDS) bits cleared. The requested word is then returned with `cpu_ready`, and a line at the same index with a different tag is replaced.
- R2: A read hit asserts `cpu_ready` in the same cycle as `cpu_req`, returns the cached word, and leaves `bus_req` low.
- R3: A write hit issues one bus write (`bus_we` high) of `cpu_wdata` to `cpu_addr` and updates the cached word, so a following read hits with the new value.
- R4: With write-allocate off, a write miss issues one bus write and installs nothing, so a following read of that address misses and fetches the written value from memory.
- R5: A snooped bus read (`snp_we` low) changes neither residency nor data.
- R6: A snooped write to an address whose line is not resident has no effect. A snooped write whose `snp_id` equals the cache's own ID also has no effect.
- R7: With the update option off, a snooped write from another ID to a resident line invalidates that line from the next cycle. Reads of the line then miss, and the refetch returns the memory value.
- R8: With the update option on, a snooped write from another ID to a resident line writes `snp_wdata` into that word and keeps the line valid, so a later read hits with the new data.
- R9: With write-allocate on, a write miss performs the bus write and then a full line fetch, after which reads of that line hit. The written word reads back with the written value.
- R10: If a snooped write from another ID hits the same line in the same cycle as a local read hit on it, the read is not answered from the cache. It is handled as a miss and refetched from memory.
- R11: Any request that needs the bus keeps `cpu_ready` low until a beat has completed with `bus_gnt` and `bus_ack` both high. While a beat is pending, `bus_req`, `bus_we` and `bus_addr` hold steady.
- R12: During and right after reset, `bus_req` and `cpu_ready` are low and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on a read |
| cpu_ready | output | 1 | One-cycle completion strobe |
| bus_req | output | 1 | Bus transaction pending |
| bus_gnt | input | 1 | Arbiter grant |
| bus_we | output | 1 | 1 = single-word write, 0 = line-fetch beat |
| bus_addr | output | ADDR_W | Word address of the current beat |
| bus_wdata | output | DATA_W | Write data to memory |
| bus_id | output | ID_W | This cache's originator ID |
| bus_ack | input | 1 | Memory acknowledge of the current beat |
| bus_rdata | input | DATA_W | Memory read data, valid with acknowledge |
| snp_valid | input | 1 | Observed bus transaction present |
| snp_we | input | 1 | Observed transaction is a write |
| snp_id | input | ID_W | Originator ID of the observed transaction |
| snp_addr | input | ADDR_W | Word address of the observed transaction |
| snp_wdata | input | DATA_W | Data of the observed write |

## Verification
A wrong valid bit or tag shows up at the first request that touches that line. A read hit that should be a miss returns its data in the request cycle with `bus_req` still low. A miss that should be a hit raises `bus_req` one cycle after the request. A stale word shows up as a mismatch in `cpu_rdata` on the next hit. A snoop that should have invalidated or updated the line shows up one cycle later, on the very next read. Fetch-order and beat-count faults appear in the sequence of `bus_addr` values during the fill and in how many beats complete before `cpu_ready`.

// File: rtl/wtc_pkg.sv
// Shared types for the write-through snooping cache.
// Assumes nothing beyond the users importing it.
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // accept processor requests
        ST_WR   = 2'd1,   // single-word write on the bus
        ST_FILL = 2'd2,   // line fetch, one word per beat
        ST_DONE = 2'd3    // one-cycle completion to the processor
    } wtc_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
// Valid bits and tags, one register pair per line.
// Port a serves the controller lookup, port b the snoop lookup.
// A clear wins over a set to the same line in the same cycle.
module wtc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 4,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output logic             a_valid,
    output logic [TAG_W-1:0] a_tag,
    input  logic [IDX_W-1:0] b_idx,
    output logic             b_valid,
    output logic [TAG_W-1:0] b_tag,
    input  logic             set_en,
    input  logic             set_valid,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [TAG_W-1:0] set_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    output logic [LINES-1:0] valid_vec
);
    logic [TAG_W-1:0] tag_arr [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic             v_q;
        logic [TAG_W-1:0] t_q;

        // Valid bit: cleared by reset or snoop, written by the controller
        always_ff @(posedge clk) begin
            if (!rst_n)
                v_q <= 1'b0;
            else if (clr_en && clr_idx == IDX_W'(i))
                v_q <= 1'b0;
            else if (set_en && set_idx == IDX_W'(i))
                v_q <= set_valid;
        end

        // Tag register: written together with the valid bit
        always_ff @(posedge clk) begin
            if (set_en && set_idx == IDX_W'(i))
                t_q <= set_tag;
        end

        assign valid_vec[i] = v_q;
        assign tag_arr[i]   = t_q;
    end

    assign a_valid = valid_vec[a_idx];
    assign a_tag   = tag_arr[a_idx];
    assign b_valid = valid_vec[b_idx];
    assign b_tag   = tag_arr[b_idx];
endmodule

// File: rtl/wtc_data_store.sv
// Line data storage, one write port and one combinational read port.
// Assumes the caller has already resolved write priority.
module wtc_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS),
    localparam int DEPTH = LINES * WORDS
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [OFF_W-1:0]  w_off,
    input  logic [DATA_W-1:0] w_data,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic [OFF_W-1:0]  r_off,
    output logic [DATA_W-1:0] r_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Word write
    always_ff @(posedge clk) begin
        if (we)
            mem[{w_idx, w_off}] <= w_data;
    end

    assign r_data = mem[{r_idx, r_off}];
endmodule

// File: rtl/wtc_ctrl.sv
// Request sequencer: read hits, line fills, write-through and optional
// write-allocate. Assumes one bus beat completes per cycle with grant and
// acknowledge both high, and that no other cache writes while this one
// holds the bus; a snooped write to the line being filled still
// suppresses its valid bit as a safety net.
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 32,
    parameter int LINES       = 16,
    parameter int WORDS       = 4,
    parameter bit WRITE_ALLOC = 1'b0,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              use_latched,
    output logic [DATA_W-1:0] rdata_q,
    output logic [IDX_W-1:0]  lk_idx,
    input  logic              lk_valid,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic              snp_res_hit,
    input  logic [IDX_W-1:0]  snp_idx,
    input  logic              snp_wr_other,
    input  logic [LINE_W-1:0] snp_line,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_gnt,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              dw_en,
    output logic [OFF_W-1:0]  dw_off,
    output logic [DATA_W-1:0] dw_data,
    output logic              ts_en,
    output logic              ts_valid,
    output logic [TAG_W-1:0]  ts_tag
);
    wtc_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [OFF_W-1:0]  beat;
    logic              alloc_q;
    logic              taint_q;

    logic [OFF_W-1:0]  cpu_off, q_off;
    logic [IDX_W-1:0]  cpu_idx, q_idx;
    logic [TAG_W-1:0]  cpu_tag, q_tag, cmp_tag;
    logic              idle, hit, kill, rd_hit_ok, beat_done, last_beat, snp_fill_now;

    assign cpu_off = cpu_addr[OFF_W-1:0];
    assign cpu_idx = cpu_addr[OFF_W +: IDX_W];
    assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign q_off   = addr_q[OFF_W-1:0];
    assign q_idx   = addr_q[OFF_W +: IDX_W];
    assign q_tag   = addr_q[ADDR_W-1 -: TAG_W];

    assign idle      = (state == ST_IDLE);
    assign lk_idx    = idle ? cpu_idx : q_idx;
    assign cmp_tag   = idle ? cpu_tag : q_tag;
    assign hit       = lk_valid && (lk_tag == cmp_tag);
    assign kill      = snp_res_hit && (snp_idx == lk_idx);
    assign rd_hit_ok = idle && cpu_req && !cpu_we && hit && !kill;
    assign beat_done = bus_gnt && bus_ack;
    assign last_beat = (beat == OFF_W'(WORDS - 1));
    assign snp_fill_now = snp_wr_other && (snp_line == addr_q[ADDR_W-1:OFF_W]);

    assign cpu_ready   = rd_hit_ok || (state == ST_DONE);
    assign use_latched = (state == ST_DONE);
    assign bus_req     = (state == ST_WR) || (state == ST_FILL);
    assign bus_we      = (state == ST_WR);
    assign bus_addr    = (state == ST_WR) ? addr_q : {q_tag, q_idx, beat};
    assign bus_wdata   = wdata_q;
    assign ts_tag      = cmp_tag;

    // Storage write requests issued by the current state
    always_comb begin
        dw_en    = 1'b0;
        dw_off   = q_off;
        dw_data  = wdata_q;
        ts_en    = 1'b0;
        ts_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req && !cpu_we && !rd_hit_ok)
                    ts_en = 1'b1;                  // drop the line before refilling it
            end
            ST_WR: begin
                if (beat_done && hit)
                    dw_en = 1'b1;                  // write hit: refresh the cached word
                if (beat_done && alloc_q)
                    ts_en = 1'b1;                  // allocate: invalidate, then fill
            end
            ST_FILL: begin
                if (beat_done) begin
                    dw_en   = 1'b1;
                    dw_off  = beat;
                    dw_data = bus_rdata;
                    if (last_beat) begin
                        ts_en    = 1'b1;
                        ts_valid = !taint_q && !snp_fill_now;
                    end
                end
            end
            default: ;
        endcase
    end

    // State sequencing and request latching
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            beat    <= '0;
            alloc_q <= 1'b0;
            taint_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cpu_req && !rd_hit_ok) begin
                        addr_q  <= cpu_addr;
                        wdata_q <= cpu_wdata;
                        beat    <= '0;
                        taint_q <= 1'b0;
                        alloc_q <= WRITE_ALLOC && !hit;
                        state   <= cpu_we ? ST_WR : ST_FILL;
                    end
                end
                ST_WR: begin
                    if (beat_done) begin
                        beat    <= '0;
                        taint_q <= 1'b0;
                        state   <= alloc_q ? ST_FILL : ST_DONE;
                    end
                end
                ST_FILL: begin
                    if (snp_fill_now)
                        taint_q <= 1'b1;
                    if (beat_done) begin
                        if (beat == q_off)
                            rdata_q <= bus_rdata;
                        beat <= beat + 1'b1;
                        if (last_beat)
                            state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wt_snoop_cache.sv
// Direct-mapped write-through data cache with bus snooping.
// Assumes word addressing, power-of-two LINES and WORDS, and that a
// snooped write comes from another cache that has written it through.
// Snoop effect: invalidate (SNOOP_UPDATE=0) or overwrite (SNOOP_UPDATE=1).
module wt_snoop_cache #(
    parameter int             ADDR_W       = 10,
    parameter int             DATA_W       = 32,
    parameter int             LINES        = 16,
    parameter int             WORDS        = 4,
    parameter int             ID_W         = 2,
    parameter logic [ID_W-1:0] MY_ID       = '0,
    parameter bit             SNOOP_UPDATE = 1'b0,
    parameter bit             WRITE_ALLOC  = 1'b0,
    localparam int OFF_W  = $clog2(WORDS),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [ID_W-1:0]   bus_id,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_we,
    input  logic [ID_W-1:0]   snp_id,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_wdata
);
    logic [IDX_W-1:0]  lk_idx, snp_idx;
    logic [TAG_W-1:0]  lk_tag, snp_tag, sb_tag, ts_tag;
    logic [OFF_W-1:0]  snp_off, dw_off, ds_off;
    logic              lk_valid, sb_valid, snp_wr_other, snp_res_hit;
    logic              ts_en, ts_valid, clr_en, dw_en, ds_we, use_latched;
    logic [DATA_W-1:0] dw_data, ds_data, rdata_q, store_rd;
    logic [LINES-1:0]  valid_vec;

    assign bus_id       = MY_ID;
    assign snp_idx      = snp_addr[OFF_W +: IDX_W];
    assign snp_tag      = snp_addr[ADDR_W-1 -: TAG_W];
    assign snp_off      = snp_addr[OFF_W-1:0];
    assign snp_wr_other = snp_valid && snp_we && (snp_id != MY_ID);
    assign snp_res_hit  = snp_wr_other && sb_valid && (sb_tag == snp_tag);

    // Snoop effect picked by parameter: drop the line or patch the word
    if (SNOOP_UPDATE) begin : g_upd
        assign clr_en  = 1'b0;
        assign ds_we   = dw_en || snp_res_hit;
        assign ds_off  = dw_en ? dw_off  : snp_off;
        assign ds_data = dw_en ? dw_data : snp_wdata;
    end else begin : g_inv
        assign clr_en  = snp_res_hit;
        assign ds_we   = dw_en;
        assign ds_off  = dw_off;
        assign ds_data = dw_data;
    end

    logic [IDX_W-1:0] ds_idx;
    assign ds_idx    = dw_en ? lk_idx : snp_idx;
    assign cpu_rdata = use_latched ? rdata_q : store_rd;

    wtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .a_idx(lk_idx), .a_valid(lk_valid), .a_tag(lk_tag),
        .b_idx(snp_idx), .b_valid(sb_valid), .b_tag(sb_tag),
        .set_en(ts_en), .set_valid(ts_valid), .set_idx(lk_idx), .set_tag(ts_tag),
        .clr_en(clr_en), .clr_idx(snp_idx),
        .valid_vec(valid_vec)
    );

    wtc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk(clk), .we(ds_we), .w_idx(ds_idx), .w_off(ds_off), .w_data(ds_data),
        .r_idx(cpu_addr[OFF_W +: IDX_W]), .r_off(cpu_addr[OFF_W-1:0]), .r_data(store_rd)
    );

    wtc_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS),
        .WRITE_ALLOC(WRITE_ALLOC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .use_latched(use_latched), .rdata_q(rdata_q),
        .lk_idx(lk_idx), .lk_valid(lk_valid), .lk_tag(lk_tag),
        .snp_res_hit(snp_res_hit), .snp_idx(snp_idx),
        .snp_wr_other(snp_wr_other), .snp_line(snp_addr[ADDR_W-1:OFF_W]),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .dw_en(dw_en), .dw_off(dw_off), .dw_data(dw_data),
        .ts_en(ts_en), .ts_valid(ts_valid), .ts_tag(ts_tag)
    );
endmodule

// File: rtl/wtc_chk.sv
// Protocol and coherence checks for wt_snoop_cache, attached by bind.
// Assumes it sees the top's ports and its valid-bit vector.
module wtc_chk #(
    parameter int             ADDR_W       = 10,
    parameter int             LINES        = 16,
    parameter int             ID_W         = 2,
    parameter logic [ID_W-1:0] MY_ID       = '0,
    parameter bit             SNOOP_UPDATE = 1'b0,
    localparam int IDX_W = $clog2(LINES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_ack,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snp_valid,
    input logic [ID_W-1:0]   snp_id,
    input logic              snp_res_hit,
    input logic [IDX_W-1:0]  snp_idx,
    input logic              ts_en,
    input logic [LINES-1:0]  valid_vec
);
    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !cpu_ready && valid_vec == '0));

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !(bus_gnt && bus_ack)) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R11
    ready_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && $past(bus_req)) |-> $past(bus_gnt && bus_ack));

    // R2
    hit_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !bus_req);

    // R6
    own_id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_id == MY_ID && !ts_en) |=> $stable(valid_vec));

    if (!SNOOP_UPDATE) begin : g_inv_chk
        // R7
        snoop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            snp_res_hit |=> !valid_vec[$past(snp_idx)]);
    end else begin : g_upd_chk
        // R8
        snoop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (snp_res_hit && !ts_en) |=> valid_vec[$past(snp_idx)]);
    end
endmodule

bind wt_snoop_cache wtc_chk #(
    .ADDR_W(ADDR_W), .LINES(LINES), .ID_W(ID_W), .MY_ID(MY_ID), .SNOOP_UPDATE(SNOOP_UPDATE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_ack(bus_ack), .bus_we(bus_we), .bus_addr(bus_addr),
    .snp_valid(snp_valid), .snp_id(snp_id), .snp_res_hit(snp_res_hit),
    .snp_idx(snp_idx), .ts_en(ts_en), .valid_vec(valid_vec)
);

// File: tb/sim_wt_snoop_cache.sv
// Bench: u0 invalidates on snoop without write-allocate, u1 updates on
// snoop with write-allocate. Each has its own memory model and responder.
module sim_wt_snoop_cache;
    localparam int AW = 10;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic          cpu_req [2], cpu_we [2], cpu_ready [2];
    logic [AW-1:0] cpu_addr [2];
    logic [DW-1:0] cpu_wdata [2], cpu_rdata [2];
    logic          bus_req [2], bus_gnt [2], bus_we [2], bus_ack [2];
    logic [AW-1:0] bus_addr [2];
    logic [DW-1:0] bus_wdata [2], bus_rdata [2];
    logic [1:0]    bus_id [2];
    logic          snp_valid [2], snp_we [2];
    logic [1:0]    snp_id [2];
    logic [AW-1:0] snp_addr [2];
    logic [DW-1:0] snp_wdata [2];

    logic [DW-1:0] mem [2][1024];
    int            wcnt [2];
    int            rd_beats [2], wr_beats [2];
    logic [AW-1:0] rd_log [2][4];
    int            errors = 0, checks = 0;

    wt_snoop_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]), .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]),
        .cpu_rdata(cpu_rdata[0]), .cpu_ready(cpu_ready[0]),
        .bus_req(bus_req[0]), .bus_gnt(bus_gnt[0]), .bus_we(bus_we[0]), .bus_addr(bus_addr[0]),
        .bus_wdata(bus_wdata[0]), .bus_id(bus_id[0]), .bus_ack(bus_ack[0]), .bus_rdata(bus_rdata[0]),
        .snp_valid(snp_valid[0]), .snp_we(snp_we[0]), .snp_id(snp_id[0]),
        .snp_addr(snp_addr[0]), .snp_wdata(snp_wdata[0])
    );

    wt_snoop_cache #(.SNOOP_UPDATE(1'b1), .WRITE_ALLOC(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]), .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]),
        .cpu_rdata(cpu_rdata[1]), .cpu_ready(cpu_ready[1]),
        .bus_req(bus_req[1]), .bus_gnt(bus_gnt[1]), .bus_we(bus_we[1]), .bus_addr(bus_addr[1]),
        .bus_wdata(bus_wdata[1]), .bus_id(bus_id[1]), .bus_ack(bus_ack[1]), .bus_rdata(bus_rdata[1]),
        .snp_valid(snp_valid[1]), .snp_we(snp_we[1]), .snp_id(snp_id[1]),
        .snp_addr(snp_addr[1]), .snp_wdata(snp_wdata[1])
    );

    assign bus_rdata[0] = mem[0][bus_addr[0]];
    assign bus_rdata[1] = mem[1][bus_addr[1]];

    // Memory model: initial fill, completed beats, other caches' write-through
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                for (int a = 0; a < 1024; a++) mem[k][a] = 32'hA000_0000 | a;
                rd_beats[k] = 0;
                wr_beats[k] = 0;
            end else begin
                if (bus_req[k] && bus_gnt[k] && bus_ack[k]) begin
                    if (bus_we[k]) begin
                        mem[k][bus_addr[k]] = bus_wdata[k];
                        wr_beats[k]++;
                    end else begin
                        rd_log[k][rd_beats[k] % 4] = bus_addr[k];
                        rd_beats[k]++;
                    end
                end
                if (snp_valid[k] && snp_we[k] && snp_id[k] != 2'd0)
                    mem[k][snp_addr[k]] = snp_wdata[k];
            end
        end
    end

    // Arbiter and memory timing: grant after two cycles, ack every other cycle
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (!bus_req[k] || !rst_n) begin
                wcnt[k] = 0;
                bus_gnt[k] = 1'b0;
                bus_ack[k] = 1'b0;
            end else begin
                wcnt[k]++;
                bus_gnt[k] = (wcnt[k] >= 2);
                bus_ack[k] = bus_gnt[k] && !bus_ack[k];
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One processor request, optionally with a snooped write in its first cycle
    task automatic cpu_op(input int k, input bit we, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input bit co_snp,
                          input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                          output logic [DW-1:0] rd, output bit used_bus,
                          output bit beat_seen);
        int n = 0;
        int start;
        @(negedge clk);
        cpu_req[k] = 1'b1; cpu_we[k] = we; cpu_addr[k] = a; cpu_wdata[k] = d;
        if (co_snp) begin
            snp_valid[k] = 1'b1; snp_we[k] = 1'b1; snp_id[k] = 2'd1;
            snp_addr[k] = sa; snp_wdata[k] = sd;
        end
        start = rd_beats[k] + wr_beats[k];
        used_bus = 1'b0;
        #1;
        while (!cpu_ready[k] && n < 1000) begin
            if (bus_req[k]) used_bus = 1'b1;
            @(negedge clk);
            snp_valid[k] = 1'b0;
            #1;
            n++;
        end
        rd = cpu_rdata[k];
        beat_seen = (rd_beats[k] + wr_beats[k]) != start;
        @(negedge clk);
        cpu_req[k] = 1'b0;
        snp_valid[k] = 1'b0;
    endtask

    task automatic snoop(input int k, input bit we, input logic [1:0] id,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        snp_valid[k] = 1'b1; snp_we[k] = we; snp_id[k] = id; snp_addr[k] = a; snp_wdata[k] = d;
        @(negedge clk);
        snp_valid[k] = 1'b0;
    endtask

    // Vector: we | addr | wdata | expected read data | kind (0 hit, 1 fill, 2 write)
    localparam logic [76:0] TV [8] = '{
        {1'b0, 10'h045, 32'h0,         32'hA000_0045, 2'd1},   // R1 cold miss
        {1'b0, 10'h047, 32'h0,         32'hA000_0047, 2'd0},   // R2 hit
        {1'b1, 10'h046, 32'h1111_1111, 32'h0,         2'd2},   // R3 write hit
        {1'b0, 10'h046, 32'h0,         32'h1111_1111, 2'd0},   // R3 readback
        {1'b1, 10'h0A0, 32'h2222_2222, 32'h0,         2'd2},   // R4 write miss
        {1'b0, 10'h0A0, 32'h0,         32'h2222_2222, 2'd1},   // R4 not allocated
        {1'b0, 10'h085, 32'h0,         32'hA000_0085, 2'd1},   // R1 conflict replace
        {1'b0, 10'h045, 32'h0,         32'hA000_0045, 2'd1}    // R1 evicted line
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] rd;
        bit ub, bs;
        for (int k = 0; k < 2; k++) begin
            cpu_req[k] = 0; cpu_we[k] = 0; cpu_addr[k] = '0; cpu_wdata[k] = '0;
            snp_valid[k] = 0; snp_we[k] = 0; snp_id[k] = '0; snp_addr[k] = '0; snp_wdata[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        for (int k = 0; k < 2; k++) begin
            check(!bus_req[k], "R12", "bus_req after reset", {31'd0, bus_req[k]}, 0);
            check(!cpu_ready[k], "R12", "cpu_ready after reset", {31'd0, cpu_ready[k]}, 0);
        end

        // Vector walk on u0
        for (int i = 0; i < 8; i++) begin
            int rb0, wb0;
            logic [1:0] kind;
            logic [AW-1:0] a;
            kind = TV[i][1:0];
            a = TV[i][75:66];
            rb0 = rd_beats[0]; wb0 = wr_beats[0];
            cpu_op(0, TV[i][76], a, TV[i][65:34], 1'b0, '0, '0, rd, ub, bs);
            if (!TV[i][76])
                check(rd == TV[i][33:2], "R1/R2/R3/R4", $sformatf("vec %0d data", i), rd, TV[i][33:2]);
            check(ub == (kind != 2'd0), "R2", $sformatf("vec %0d bus use", i), {31'd0, ub}, {31'd0, kind != 2'd0});
            if (kind != 2'd0)
                check(bs, "R11", $sformatf("vec %0d ready only after a beat", i), {31'd0, bs}, 1);
            check(rd_beats[0] - rb0 == (kind == 2'd1 ? 4 : 0), "R1", $sformatf("vec %0d fetch beats", i),
                  rd_beats[0] - rb0, (kind == 2'd1 ? 4 : 0));
            check(wr_beats[0] - wb0 == (kind == 2'd2 ? 1 : 0), "R3", $sformatf("vec %0d write beats", i),
                  wr_beats[0] - wb0, (kind == 2'd2 ? 1 : 0));
            if (kind == 2'd1)
                for (int b = 0; b < 4; b++)
                    check(rd_log[0][b] == ({a[9:2], 2'b00} + b), "R1", $sformatf("vec %0d beat %0d addr", i, b),
                          {22'd0, rd_log[0][b]}, {22'd0, a[9:2], 2'b00} + b);
            if (kind == 2'd2)
                check(mem[0][a] == TV[i][65:34], "R3", $sformatf("vec %0d memory written", i), mem[0][a], TV[i][65:34]);
        end

        // R5 snooped read ignored
        snoop(0, 1'b0, 2'd1, 10'h045, 32'hDEAD_0001);
        cpu_op(0, 1'b0, 10'h045, '0, 1'b0, '0, '0, rd, ub, bs);
        check(!ub && rd == 32'hA000_0045, "R5", "hit after snooped read", rd, 32'hA000_0045);

        // R6 non-resident and own-ID snooped writes ignored
        snoop(0, 1'b1, 2'd1, 10'h3C5, 32'h3333_3333);
        cpu_op(0, 1'b0, 10'h045, '0, 1'b0, '0, '0, rd, ub, bs);
        check(!ub && rd == 32'hA000_0045, "R6", "hit after non-resident snoop", {31'd0, ub}, 0);
        snoop(0, 1'b1, 2'd0, 10'h045, 32'h4444_4444);
        cpu_op(0, 1'b0, 10'h045, '0, 1'b0, '0, '0, rd, ub, bs);
        check(!ub && rd == 32'hA000_0045, "R6", "hit after own-ID snoop", rd, 32'hA000_0045);

        // R7 snooped write invalidates
        snoop(0, 1'b1, 2'd1, 10'h046, 32'h5555_5555);
        cpu_op(0, 1'b0, 10'h045, '0, 1'b0, '0, '0, rd, ub, bs);
        check(ub, "R7", "miss after invalidating snoop", {31'd0, ub}, 1);
        check(rd == 32'hA000_0045, "R7", "refetched word", rd, 32'hA000_0045);
        cpu_op(0, 1'b0, 10'h046, '0, 1'b0, '0, '0, rd, ub, bs);
        check(!ub && rd == 32'h5555_5555, "R7", "refilled line carries snooped data", rd, 32'h5555_5555);

        // R10 snoop collides with a read hit on the same line
        cpu_op(0, 1'b0, 10'h047, '0, 1'b1, 10'h044, 32'h6666_6666, rd, ub, bs);
        check(ub, "R10", "colliding read refetched", {31'd0, ub}, 1);
        check(rd == 32'hA000_0047, "R10", "colliding read data", rd, 32'hA000_0047);
        cpu_op(0, 1'b0, 10'h044, '0, 1'b0, '0, '0, rd, ub, bs);
        check(!ub && rd == 32'h6666_6666, "R10", "line refreshed after collision", rd, 32'h6666_6666);

        // R8 update policy on u1
        cpu_op(1, 1'b0, 10'h045, '0, 1'b0, '0, '0, rd, ub, bs);
        check(ub && rd == 32'hA000_0045, "R8", "u1 initial fill", rd, 32'hA000_0045);
        snoop(1, 1'b1, 2'd1, 10'h046, 32'h7777_7777);
        cpu_op(1, 1'b0, 10'h046, '0, 1'b0, '0, '0, rd, ub, bs);
        check(!ub, "R8", "line stays resident after update", {31'd0, ub}, 0);
        check(rd == 32'h7777_7777, "R8", "updated word", rd, 32'h7777_7777);

        // R9 write-allocate on u1
        begin
            int rb1, wb1;
            rb1 = rd_beats[1]; wb1 = wr_beats[1];
            cpu_op(1, 1'b1, 10'h1C0, 32'h8888_8888, 1'b0, '0, '0, rd, ub, bs);
            check(wr_beats[1] - wb1 == 1, "R9", "allocate write beats", wr_beats[1] - wb1, 1);
            check(rd_beats[1] - rb1 == 4, "R9", "allocate fetch beats", rd_beats[1] - rb1, 4);
        end
        cpu_op(1, 1'b0, 10'h1C0, '0, 1'b0, '0, '0, rd, ub, bs);
        check(!ub && rd == 32'h8888_8888, "R9", "written word hits", rd, 32'h8888_8888);
        cpu_op(1, 1'b0, 10'h1C3, '0, 1'b0, '0, '0, rd, ub, bs);
        check(!ub && rd == 32'hA000_01C3, "R9", "neighbour word hits", rd, 32'hA000_01C3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule